// File: doc/BRIEF.md
# 64-Bit Register Access Mailbox

This block gives a 32-bit configuration slave port access to 64-bit registers on a back-end register bus. Three mailbox registers are used for this. The address register names the target: a routing path in its upper bits and a device address in its low bits. The data-low and data-high registers move the two halves of the 64-bit value. A 64-bit transfer cannot cross the 32-bit port in one access, so the block holds whichever half is not moving at that moment. A read of data low fetches the whole 64-bit register, returns the lower half and keeps the upper half for a later read of data high. A write of data low only stores the value. A following write of data high sends the complete 64-bit value to the back end.

The config master raises `cfg_req` with the offset, the direction and the write data, and holds them until it sees `cfg_rdy`. Accesses that touch only local state complete in the cycle they are presented. Accesses that need the back end are stalled: the block raises `bus_req` and holds it, with the address and write data steady, until the register bus answers with a one-cycle `bus_ack`. One cycle later `cfg_rdy` completes the config access.

Top module: `wide_reg_mailbox`

## Requirements
- R1: After reset, the address register and the saved upper half read as zero. The stored lower half is also zero, so a data-high write issued before any data-low write sends zeros in bits 31:0.
- R2: Only the byte offsets F4h (address), F8h (data low) and FCh (data high) are decoded. A read at any other offset returns zero and a write there changes nothing. Both complete at once, without a back-end cycle.
- R3: A write at F4h sets the address register and a read at F4h returns it, with no back-end cycle. During back-end cycles, bits 13:0 of the address appear on `bus_dev` and bits 31:14 on `bus_route`.
- R4: A read at F8h starts exactly one back-end read (`bus_we` low). It returns bits 31:0 of the value that the back end supplies.
- R5: A read at FCh starts no back-end cycle. It returns bits 63:32 saved by the most recent F8h read. Writes do not change this saved half.
- R6: A write at F8h stores the value and starts no back-end cycle.
- R7: A write at FCh starts exactly one back-end write (`bus_we` high) whose `bus_wdata` is {written value, stored low value}. The stored low value is kept for later data-high writes.
- R8: While a back-end cycle is outstanding, `cfg_rdy` stays low and `bus_req`, `bus_route`, `bus_dev` and `bus_wdata` stay steady until `bus_ack`. With the ack given k cycles after `bus_req` rises, `cfg_rdy` rises k+2 cycles after the config request is first presented.
- R9: Any back-end ack latency from zero cycles upward gives the same data results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Config access request, held until cfg_rdy |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_off | input | OFF_W | Byte offset of the config access |
| cfg_wdata | input | DW | Config write data |
| cfg_rdata | output | DW | Config read data, valid while cfg_rdy |
| cfg_rdy | output | 1 | Config access completes this cycle |
| bus_req | output | 1 | Back-end request, held until bus_ack |
| bus_we | output | 1 | Back-end direction, 1 = write |
| bus_route | output | DW-DEV_W | Routing part of the target address |
| bus_dev | output | DEV_W | Device address part of the target address |
| bus_wdata | output | 2*DW | Back-end write data |
| bus_rdata | input | 2*DW | Back-end read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle back-end completion |

## Verification
The bench builds the block with its default parameters: a 32-bit config word, a 14-bit device field and an 8-bit offset. These defaults bring all three mailbox offsets and an undecoded offset within reach, and they let the route and device split be checked at bit 14. Its behavioural register file answers with an adjustable ack latency, set to zero and then to several cycles. This exercises the exact stall length and shows that the data results do not depend on timing. Back-end transactions are counted, so accesses that must stay local can be told apart from accesses that reach the bus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ADDR,
        ACC_LO,
        ACC_HI
    } acc_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_BUSY,
        SQ_DONE
    } seq_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int OFF_W = 8,
    parameter logic [OFF_W-1:0] OFS_ADDR = 'hF4,
    parameter logic [OFF_W-1:0] OFS_LO   = 'hF8,
    parameter logic [OFF_W-1:0] OFS_HI   = 'hFC
) (
    input  logic [OFF_W-1:0] off,
    input  logic             we,
    output acc_e             kind,
    output logic             needs_bus
);

    always_comb begin
        if (off == OFS_ADDR)      kind = ACC_ADDR;
        else if (off == OFS_LO)   kind = ACC_LO;
        else if (off == OFS_HI)   kind = ACC_HI;
        else                      kind = ACC_NONE;
        // low-word read fetches, high-word write commits
        needs_bus = ((kind == ACC_LO) && !we) || ((kind == ACC_HI) && we);
    end

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_req,
    input  logic cfg_we,
    input  logic needs_bus,
    input  logic bus_ack,
    output logic bus_req,
    output logic bus_we,
    output logic cfg_rdy,
    output logic start,
    output logic rd_ack,
    output logic in_done,
    output logic done_rd
);

    typedef struct packed {
        seq_e st;
        logic we;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (cfg_req && needs_bus) begin
                    s_d.st = SQ_BUSY;
                    s_d.we = cfg_we;
                    start  = 1'b1;
                end
            end
            SQ_BUSY: begin
                if (bus_ack) s_d.st = SQ_DONE;
            end
            SQ_DONE: s_d.st = SQ_IDLE;
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= SQ_IDLE;
            s_q.we <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_req = (s_q.st == SQ_BUSY);
        bus_we  = bus_req && s_q.we;
        rd_ack  = bus_req && bus_ack && !s_q.we;
        in_done = (s_q.st == SQ_DONE);
        done_rd = in_done && !s_q.we;
        cfg_rdy = ((s_q.st == SQ_IDLE) && cfg_req && !needs_bus) || in_done;
    end

    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req); // R8
    AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cfg_rdy); // R8
    AST_ACK_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req && cfg_rdy); // R8

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_e          kind,
    input  logic          wr_local,
    input  logic          start,
    input  logic          start_we,
    input  logic [DW-1:0] wdata,
    input  logic          rd_ack,
    input  logic [2*DW-1:0] bus_rdata,
    input  logic          done_rd,
    output logic [DW-1:0] addr,
    output logic [2*DW-1:0] bus_wdata,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] lo;
        logic [DW-1:0] whi;
        logic [DW-1:0] hi_sv;
        logic [DW-1:0] lo_rd;
    } st_t;

    st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_local) begin
            if (kind == ACC_ADDR) r_d.addr = wdata;
            if (kind == ACC_LO)   r_d.lo   = wdata;
        end
        if (start && start_we) r_d.whi = wdata;
        if (rd_ack) begin
            r_d.lo_rd = bus_rdata[DW-1:0];
            r_d.hi_sv = bus_rdata[2*DW-1:DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        addr      = r_q.addr;
        bus_wdata = {r_q.whi, r_q.lo};
        if (done_rd) begin
            rdata = r_q.lo_rd;
        end else begin
            case (kind)
                ACC_ADDR: rdata = r_q.addr;
                ACC_HI:   rdata = r_q.hi_sv;
                default:  rdata = '0;
            endcase
        end
    end

    AST_HI_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |=> $stable(r_q.hi_sv)); // R5
    AST_LO_KEPT_BY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_local && kind == ACC_LO) |=> $stable(r_q.lo)); // R7

endmodule

// File: rtl/wide_reg_mailbox.sv
module wide_reg_mailbox
    import mbx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEV_W = 14,
    parameter int OFF_W = 8,
    parameter logic [OFF_W-1:0] OFS_ADDR = 'hF4,
    parameter logic [OFF_W-1:0] OFS_LO   = 'hF8,
    parameter logic [OFF_W-1:0] OFS_HI   = 'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    output logic              cfg_rdy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DW-DEV_W-1:0] bus_route,
    output logic [DEV_W-1:0]  bus_dev,
    output logic [2*DW-1:0]   bus_wdata,
    input  logic [2*DW-1:0]   bus_rdata,
    input  logic              bus_ack
);

    acc_e          kind;
    logic          needs_bus;
    logic          start, rd_ack, in_done, done_rd;
    logic          wr_local;
    logic [DW-1:0] addr;

    mbx_decode #(
        .OFF_W(OFF_W), .OFS_ADDR(OFS_ADDR), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)
    ) u_dec (
        .off(cfg_off), .we(cfg_we), .kind(kind), .needs_bus(needs_bus)
    );

    mbx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .needs_bus(needs_bus), .bus_ack(bus_ack), .bus_req(bus_req),
        .bus_we(bus_we), .cfg_rdy(cfg_rdy), .start(start), .rd_ack(rd_ack),
        .in_done(in_done), .done_rd(done_rd)
    );

    assign wr_local = cfg_req && cfg_we && cfg_rdy && !in_done;

    mbx_store #(.DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .kind(kind), .wr_local(wr_local),
        .start(start), .start_we(cfg_we), .wdata(cfg_wdata), .rd_ack(rd_ack),
        .bus_rdata(bus_rdata), .done_rd(done_rd), .addr(addr),
        .bus_wdata(bus_wdata), .rdata(cfg_rdata)
    );

    assign bus_route = addr[DW-1:DEV_W];
    assign bus_dev   = addr[DEV_W-1:0];

    AST_BUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> $stable(bus_route) && $stable(bus_dev) && $stable(bus_wdata)); // R8
    AST_LO_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req && cfg_req && cfg_we && kind == ACC_LO |=> !bus_req); // R6
    AST_HI_READ_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req && cfg_req && !cfg_we && kind == ACC_HI |=> !bus_req); // R5
    AST_LO_READ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_we && kind == ACC_LO && cfg_rdy |-> $past(bus_ack)); // R4
    AST_UNDECODED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && kind == ACC_NONE && !bus_req |-> cfg_rdy && cfg_rdata == '0); // R2

endmodule

// File: tb/tb_wide_reg_mailbox.sv
module tb_wide_reg_mailbox;

    localparam int DW = 32;
    localparam int DEV_W = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_req = 1'b0, cfg_we = 1'b0;
    logic [7:0] cfg_off = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic cfg_rdy;
    logic bus_req, bus_we;
    logic [DW-DEV_W-1:0] bus_route;
    logic [DEV_W-1:0] bus_dev;
    logic [2*DW-1:0] bus_wdata;
    logic [2*DW-1:0] bus_rdata = '0;
    logic bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int cnt = 0;
    int bus_cnt = 0;
    logic last_we = 1'b0;
    logic [DW-1:0] last_addr = '0;
    logic [2*DW-1:0] mem [16];

    always #2 clk = ~clk;

    wide_reg_mailbox dut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rdy(cfg_rdy), .bus_req(bus_req), .bus_we(bus_we),
        .bus_route(bus_route), .bus_dev(bus_dev), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // behavioural back-end register file
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            cnt <= 0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
        end else if (bus_req) begin
            if (cnt == lat) begin
                bus_ack   <= 1'b1;
                cnt       <= 0;
                bus_cnt   <= bus_cnt + 1;
                last_we   <= bus_we;
                last_addr <= {bus_route, bus_dev};
                if (bus_we) mem[bus_dev[3:0]] <= bus_wdata;
                else        bus_rdata <= mem[bus_dev[3:0]];
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] off, input logic we, input logic [31:0] wd,
                        output logic [31:0] rd, output int waits);
        @(negedge clk);
        cfg_off = off; cfg_we = we; cfg_wdata = wd; cfg_req = 1'b1;
        #1;
        waits = 0;
        while (!cfg_rdy) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = cfg_rdata;
        @(posedge clk);
        #1;
        cfg_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int w; int c0;
        xfer(8'hF4, 1'b0, 0, rd, w);
        check("R1 address after reset", rd, 0);
        xfer(8'hFC, 1'b0, 0, rd, w);
        check("R1 saved high after reset", rd, 0);
        check("R1 no bus cycles yet", bus_cnt, 0);
        xfer(8'hF4, 1'b1, 32'h0000_0002, rd, w);
        c0 = bus_cnt;
        xfer(8'hFC, 1'b1, 32'h0000_0055, rd, w);
        check("R1 low zero at commit", mem[2], 64'h0000_0055_0000_0000);
        check("R7 one write cycle", bus_cnt - c0, 1);
    endtask

    task automatic t_addr();
        logic [31:0] rd; int w; int c0;
        c0 = bus_cnt;
        xfer(8'hF4, 1'b1, 32'hABCD_4005, rd, w);
        check("R3 address write immediate", w, 0);
        xfer(8'hF4, 1'b0, 0, rd, w);
        check("R3 address readback", rd, 32'hABCD_4005);
        check("R3 no bus cycle", bus_cnt - c0, 0);
    endtask

    task automatic t_write();
        logic [31:0] rd; int w; int c0;
        c0 = bus_cnt;
        xfer(8'hF8, 1'b1, 32'h1111_2222, rd, w);
        check("R6 low write no bus cycle", bus_cnt - c0, 0);
        check("R6 low write immediate", w, 0);
        xfer(8'hFC, 1'b1, 32'h3333_4444, rd, w);
        check("R7 write count", bus_cnt - c0, 1);
        check("R7 write direction", last_we, 1);
        check("R7 write data", mem[5], 64'h3333_4444_1111_2222);
        check("R3 route/dev split", last_addr, 32'hABCD_4005);
        check("R8 stall length", w, 3 + lat);
        xfer(8'hFC, 1'b1, 32'h7777_8888, rd, w);
        check("R7 low reused", mem[5], 64'h7777_8888_1111_2222);
    endtask

    task automatic t_read(input int dev, input logic [63:0] val);
        logic [31:0] rd; int w; int c0;
        mem[dev] = val;
        xfer(8'hF4, 1'b1, 32'h0001_0000 | dev, rd, w);
        c0 = bus_cnt;
        xfer(8'hF8, 1'b0, 0, rd, w);
        check("R4 low read data", rd, val[31:0]);
        check("R4 one read cycle", bus_cnt - c0, 1);
        check("R4 read direction", last_we, 0);
        check("R8 read stall length", w, 3 + lat);
        xfer(8'hFC, 1'b0, 0, rd, w);
        check("R5 saved high", rd, val[63:32]);
        xfer(8'hFC, 1'b0, 0, rd, w);
        check("R5 saved high again", rd, val[63:32]);
        check("R5 no bus cycle on high read", bus_cnt - c0, 1);
        xfer(8'hF8, 1'b1, 32'h0000_AAAA, rd, w);
        xfer(8'hFC, 1'b1, 32'h0000_BBBB, rd, w);
        xfer(8'hFC, 1'b0, 0, rd, w);
        check("R5 writes leave saved high", rd, val[63:32]);
        check("R9 commit after read", mem[dev], 64'h0000_BBBB_0000_AAAA);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; int w; int c0;
        xfer(8'hF4, 1'b1, 32'h0000_0009, rd, w);
        xfer(8'hF8, 1'b1, 32'hCAFE_0001, rd, w);
        c0 = bus_cnt;
        xfer(8'hF0, 1'b0, 0, rd, w);
        check("R2 undecoded read zero", rd, 0);
        check("R2 undecoded read immediate", w, 0);
        xfer(8'hF0, 1'b1, 32'hFFFF_FFFF, rd, w);
        xfer(8'h08, 1'b1, 32'hFFFF_FFFF, rd, w);
        check("R2 undecoded no bus", bus_cnt - c0, 0);
        xfer(8'hF4, 1'b0, 0, rd, w);
        check("R2 address untouched", rd, 32'h0000_0009);
        xfer(8'hFC, 1'b1, 32'h0000_0001, rd, w);
        check("R2 low untouched", mem[9], 64'h0000_0001_CAFE_0001);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_addr();
        t_write();
        t_read(6, 64'hDEAD_BEEF_0BAD_F00D);
        t_unmapped();
        lat = 4;
        t_addr();
        t_write();
        t_read(7, 64'h0123_4567_89AB_CDEF);
        lat = 1;
        t_read(3, 64'hFEDC_BA98_7654_3210);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule